// File: doc/BRIEF.md
# Temperature Conversion Mode Sequencer

This block decides when a temperature converter is told to start a measurement and how the finished measurements reach the two bytes that software reads. It takes its control bits from a register file: free-run enable, slow-rate start, slow-rate enable, a two-bit averaging code, soft reset, a one-shot write strobe and a block-update enable. It drives a start strobe and an averaging count to the converter, takes back a done pulse with a 16-bit result, and presents the result as a high and a low byte. It also raises a busy flag during one-shot work and a one-cycle new-sample strobe for the threshold logic downstream.

Three exclusive modes exist. In one-shot mode, which is the idle state after reset, each one-shot write triggers a single conversion. Free-run mode repeats conversions at a rate set by the averaging code. Slow-rate mode repeats once per second and ignores the averaging code. All timing comes from a prescaled tick input: one base unit of `UNIT_TICKS` ticks is the 200 Hz period. Moving from one running mode to another requires both mode bits to pass through zero first. Block-update locking keeps the two bytes of a value together across a split read.

Top module: `tsq_conv_seq`

## Requirements
- R1: With free-run set and slow-start clear, conversion starts repeat every 1, 2, 4 or 8 base units for averaging codes 3, 2, 1 and 0. The first start comes one full period after the mode is entered.
- R2: During free-run and one-shot conversions, `conv_avg` is 8, 4, 2 or 1 for averaging codes 0, 1, 2 and 3.
- R3: In one-shot mode, a pulse on `shot_wr` issues exactly one `conv_start` pulse. No further start follows without another write.
- R4: `busy` is 1 from the cycle `conv_start` rises for a one-shot conversion until that conversion's done pulse has been taken. It is 0 at all other times. A `shot_wr` outside one-shot mode has no effect: `busy` stays 0.
- R5: Slow-rate mode (free-run 0, slow-start 1) repeats starts every `SLOW_UNITS` base units, with `conv_avg` equal to `LOW_AVERAGES` whatever the averaging code. It is entered only if slow-enable is already 1 when slow-start is seen. Otherwise no conversions run.
- R6: While `soft_rst` is 1, all state returns to its reset value: both bytes 0, `busy` 0, no starts. When `soft_rst` returns to 0, the block resumes in one-shot mode.
- R7: With `bdu_en` set, a low-byte read (`rd_lo`) freezes both bytes until a high-byte read (`rd_hi`). Results that arrive meanwhile are held back, and the newest of them appears after the high-byte read. With `bdu_en` clear, every result is shown at once.
- R8: The result passes through unchanged as a two's-complement value at 0.01 °C per LSB. `temp_hi` carries bits 15..8 and `temp_lo` carries bits 7..0. `new_sample` pulses once, one cycle after each accepted done.
- R9: Free-run and slow-start both set is a stopped state in which no conversion starts.
- R10: The one-shot request clears itself on completion: `busy` falls after the done pulse, and a later `shot_wr` starts a new conversion.
- R11: Changing directly from one running mode to another stops all conversions. A new mode runs only after both mode bits have been seen at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled timing tick |
| shot_wr | input | 1 | One-cycle strobe: one-shot bit written with 1 |
| free_run | input | 1 | Free-run mode bit |
| slow_start | input | 1 | Slow-rate mode start bit |
| slow_enable | input | 1 | Slow-rate mode enable bit |
| avg_sel | input | 2 | Averaging code |
| soft_rst | input | 1 | Soft reset bit, synchronous |
| bdu_en | input | 1 | Block-update lock enable |
| rd_lo | input | 1 | Low byte read strobe |
| rd_hi | input | 1 | High byte read strobe |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 16 | Converter result, valid with done |
| conv_start | output | 1 | Conversion start pulse |
| conv_avg | output | 4 | Number of samples to average |
| busy | output | 1 | One-shot conversion in progress |
| temp_lo | output | 8 | Low result byte |
| temp_hi | output | 8 | High result byte |
| new_sample | output | 1 | One-cycle strobe after each new result |

## Verification
The bench builds the block with `UNIT_TICKS` = 2 and the tick held high, so a base unit is two clocks. All four free-run periods (2 to 16 clocks) and the 400-clock slow-rate period can then be measured exactly, start edge to start edge, in a short run. The converter model answers at once in the rate tests, so back-to-back periods are never starved. It waits eight cycles in the one-shot tests, which holds `busy` open long enough to sample mid-conversion. Result values step by 0x0123 from 0xFF38, so the high byte changes often and the byte-lock hold and a negative-to-positive wrap are both visible.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

   typedef enum logic [2:0] {
      TS_ARMED = 3'd0,   // one-shot mode, idle
      TS_SHOT  = 3'd1,   // one-shot conversion running
      TS_FREE  = 3'd2,   // repeating at the averaging-selected rate
      TS_SLOW  = 3'd3,   // repeating at the slow rate
      TS_HALT  = 3'd4    // stopped until both mode bits read zero
   } tsq_state_e;

   localparam int AVG_CODE_W = 2;
   localparam int AVG_CNT_W  = 4;

   // samples averaged per conversion: 8, 4, 2, 1 for codes 0..3
   function automatic logic [AVG_CNT_W-1:0] avg_count(input logic [AVG_CODE_W-1:0] code);
      return 4'd8 >> code;
   endfunction

   // free-run period in base units: 8, 4, 2, 1 for codes 0..3
   function automatic logic [3:0] free_units(input logic [AVG_CODE_W-1:0] code);
      return 4'd1 << (2'd3 - code);
   endfunction

endpackage

// File: rtl/tsq_rate_gen.sv
module tsq_rate_gen
   import tsq_pkg::*;
#(
   parameter int UNIT_TICKS = 4,
   parameter int SLOW_UNITS = 200
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic                  tick,
   input  logic                  run,
   input  logic                  slow,
   input  logic [AVG_CODE_W-1:0] avg_sel,
   output logic                  fire
);

   localparam int SLOW_TICKS = UNIT_TICKS * SLOW_UNITS;
   localparam int CNT_W      = $clog2(SLOW_TICKS + 1);

   generate
      if (UNIT_TICKS < 1) begin : g_bad_unit
         $error("tsq_rate_gen: UNIT_TICKS must be at least 1");
      end
      if (SLOW_UNITS < 8) begin : g_bad_slow
         $error("tsq_rate_gen: SLOW_UNITS must cover the longest free-run period");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] period;

   always_comb begin
      if (slow) period = CNT_W'(SLOW_TICKS);
      else      period = CNT_W'(UNIT_TICKS * int'(free_units(avg_sel)));
   end

   assign fire = run && tick && (cnt >= period - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (soft_rst || !run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= fire ? '0 : cnt + 1'b1;
      end
   end

   // R1: every period boundary restarts the count
   a_r1_wrap_restart : assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      fire |=> (cnt == '0));

   // R6: a stopped counter stays cleared
   a_r6_idle_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (!run || soft_rst) |=> (cnt == '0));

endmodule

// File: rtl/tsq_mode_ctrl.sv
module tsq_mode_ctrl
   import tsq_pkg::*;
#(
   parameter int LOW_AVERAGES = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic                  free_run,
   input  logic                  slow_start,
   input  logic                  slow_enable,
   input  logic                  shot_wr,
   input  logic [AVG_CODE_W-1:0] avg_sel,
   input  logic                  fire,
   input  logic                  conv_done,
   output tsq_state_e            state,
   output logic                  conv_start,
   output logic [AVG_CNT_W-1:0]  conv_avg,
   output logic                  busy,
   output logic                  take
);

   generate
      if (LOW_AVERAGES < 1 || LOW_AVERAGES > 8) begin : g_bad_avg
         $error("tsq_mode_ctrl: LOW_AVERAGES must lie in 1..8");
      end
   endgenerate

   logic inflight;
   logic want_free, want_slow, both_clear;

   assign want_free  = free_run && !slow_start;
   assign want_slow  = !free_run && slow_start;
   assign both_clear = !free_run && !slow_start;
   assign take       = conv_done && inflight;
   assign busy       = (state == TS_SHOT);

   always_comb begin
      if (state == TS_SLOW) conv_avg = AVG_CNT_W'(LOW_AVERAGES);
      else                  conv_avg = avg_count(avg_sel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= TS_ARMED;
         conv_start <= 1'b0;
         inflight   <= 1'b0;
      end else if (soft_rst) begin
         state      <= TS_ARMED;
         conv_start <= 1'b0;
         inflight   <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         if (conv_done) inflight <= 1'b0;
         case (state)
            TS_ARMED: begin
               if (want_free) begin
                  state <= TS_FREE;
               end else if (want_slow) begin
                  state <= slow_enable ? TS_SLOW : TS_HALT;
               end else if (!both_clear) begin
                  state <= TS_HALT;
               end else if (shot_wr) begin
                  state      <= TS_SHOT;
                  conv_start <= 1'b1;
                  inflight   <= 1'b1;
               end
            end
            TS_SHOT: begin
               if (take) state <= TS_ARMED;
            end
            TS_FREE: begin
               if (!want_free) begin
                  state <= TS_HALT;
               end else if (fire && (!inflight || conv_done)) begin
                  conv_start <= 1'b1;
                  inflight   <= 1'b1;
               end
            end
            TS_SLOW: begin
               if (!want_slow) begin
                  state <= TS_HALT;
               end else if (fire && (!inflight || conv_done)) begin
                  conv_start <= 1'b1;
                  inflight   <= 1'b1;
               end
            end
            default: begin
               if (both_clear) state <= TS_ARMED;
            end
         endcase
      end
   end

   // R4: busy only ever begins together with a start pulse
   a_r4_busy_with_start : assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      $rose(busy) |-> conv_start);

   // R3: no second start while a one-shot conversion is open
   a_r3_single_start : assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      busy |=> !conv_start);

   // R9: both mode bits set never lets a start through
   a_r9_both_set_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (free_run && slow_start) |=> !conv_start);

   // R6: soft reset silences the sequencer
   a_r6_soft_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!conv_start && !busy));

   // R11: the stopped state issues nothing
   a_r11_halt_quiet : assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (state == TS_HALT) |=> !conv_start);

   // R10: an accepted done closes the one-shot conversion
   a_r10_shot_closes : assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (busy && take) |=> !busy);

endmodule

// File: rtl/tsq_out_latch.sv
module tsq_out_latch #(
   parameter int TEMP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              bdu_en,
   input  logic              rd_lo,
   input  logic              rd_hi,
   input  logic              take,
   input  logic [TEMP_W-1:0] result,
   output logic [TEMP_W-1:0] shown,
   output logic              new_sample
);

   logic [TEMP_W-1:0] held;
   logic              held_v;
   logic              locked;
   logic              release_now;
   logic              lock_in;

   assign release_now = locked && (rd_hi || !bdu_en);
   assign lock_in     = locked || (bdu_en && rd_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shown      <= '0;
         held       <= '0;
         held_v     <= 1'b0;
         locked     <= 1'b0;
         new_sample <= 1'b0;
      end else if (soft_rst) begin
         shown      <= '0;
         held       <= '0;
         held_v     <= 1'b0;
         locked     <= 1'b0;
         new_sample <= 1'b0;
      end else begin
         new_sample <= take;
         if (release_now) begin
            locked <= 1'b0;
            held_v <= 1'b0;
            if (take)        shown <= result;
            else if (held_v) shown <= held;
         end else begin
            if (take) begin
               if (lock_in) begin
                  held   <= result;
                  held_v <= 1'b1;
               end else begin
                  shown <= result;
               end
            end
            if (bdu_en && rd_lo) locked <= 1'b1;
         end
      end
   end

   // R7: a locked word cannot move until the high byte is read
   a_r7_locked_hold : assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      (locked && bdu_en && !rd_hi) |=> $stable(shown));

   // R8: each accepted result is announced one cycle later
   a_r8_strobe_follows : assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
      take |=> new_sample);

endmodule

// File: rtl/tsq_conv_seq.sv
module tsq_conv_seq
   import tsq_pkg::*;
#(
   parameter int UNIT_TICKS   = 4,
   parameter int SLOW_UNITS   = 200,
   parameter int LOW_AVERAGES = 1,
   parameter int TEMP_W       = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  shot_wr,
   input  logic                  free_run,
   input  logic                  slow_start,
   input  logic                  slow_enable,
   input  logic [AVG_CODE_W-1:0] avg_sel,
   input  logic                  soft_rst,
   input  logic                  bdu_en,
   input  logic                  rd_lo,
   input  logic                  rd_hi,
   input  logic                  conv_done,
   input  logic [TEMP_W-1:0]     conv_result,
   output logic                  conv_start,
   output logic [AVG_CNT_W-1:0]  conv_avg,
   output logic                  busy,
   output logic [7:0]            temp_lo,
   output logic [TEMP_W-9:0]     temp_hi,
   output logic                  new_sample
);

   localparam int BYTE_W = 8;

   generate
      if (TEMP_W != 2 * BYTE_W) begin : g_bad_width
         $error("tsq_conv_seq: result must split into two bytes");
      end
   endgenerate

   tsq_state_e        state;
   logic              fire;
   logic              take;
   logic [TEMP_W-1:0] shown;

   tsq_mode_ctrl #(
      .LOW_AVERAGES (LOW_AVERAGES)
   ) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .free_run    (free_run),
      .slow_start  (slow_start),
      .slow_enable (slow_enable),
      .shot_wr     (shot_wr),
      .avg_sel     (avg_sel),
      .fire        (fire),
      .conv_done   (conv_done),
      .state       (state),
      .conv_start  (conv_start),
      .conv_avg    (conv_avg),
      .busy        (busy),
      .take        (take)
   );

   tsq_rate_gen #(
      .UNIT_TICKS (UNIT_TICKS),
      .SLOW_UNITS (SLOW_UNITS)
   ) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .tick     (tick),
      .run      ((state == TS_FREE) || (state == TS_SLOW)),
      .slow     (state == TS_SLOW),
      .avg_sel  (avg_sel),
      .fire     (fire)
   );

   tsq_out_latch #(
      .TEMP_W (TEMP_W)
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .bdu_en     (bdu_en),
      .rd_lo      (rd_lo),
      .rd_hi      (rd_hi),
      .take       (take),
      .result     (conv_result),
      .shown      (shown),
      .new_sample (new_sample)
   );

   assign temp_lo = shown[BYTE_W-1:0];
   assign temp_hi = shown[TEMP_W-1:BYTE_W];

endmodule

// File: tb/tsq_conv_seq_tb.sv
module tsq_conv_seq_tb;

   localparam int UNIT = 2;
   localparam logic [15:0] FIRST_VAL = 16'hFF38;
   localparam logic [15:0] STEP_VAL  = 16'h0123;

   // rate vectors: free_run, slow_start, slow_enable, avg code, expected gap, expected average
   localparam int NV = 7;
   localparam int V_FR [NV]  = '{1, 1, 1, 1, 0, 1, 0};
   localparam int V_LS [NV]  = '{0, 0, 0, 0, 1, 1, 1};
   localparam int V_EN [NV]  = '{0, 0, 0, 0, 1, 1, 0};
   localparam int V_AVG[NV]  = '{0, 1, 2, 3, 2, 0, 1};
   localparam int V_GAP[NV]  = '{16, 8, 4, 2, 400, 0, 0};
   localparam int V_NAV[NV]  = '{8, 4, 2, 1, 1, 0, 0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        shot_wr = 1'b0;
   logic        free_run = 1'b0;
   logic        slow_start = 1'b0;
   logic        slow_enable = 1'b0;
   logic [1:0]  avg_sel = 2'd0;
   logic        soft_rst = 1'b0;
   logic        bdu_en = 1'b0;
   logic        rd_lo = 1'b0;
   logic        rd_hi = 1'b0;
   logic        conv_done;
   logic [15:0] conv_result;
   logic        conv_start;
   logic [3:0]  conv_avg;
   logic        busy;
   logic [7:0]  temp_lo;
   logic [7:0]  temp_hi;
   logic        new_sample;

   int n_chk = 0;
   int n_fail = 0;
   int n_starts = 0;
   int n_new = 0;
   int n_done = 0;
   int lat_cfg = 0;
   int cd;
   logic [15:0] sample_val;

   always #2 clk = ~clk;

   tsq_conv_seq #(
      .UNIT_TICKS   (UNIT),
      .SLOW_UNITS   (200),
      .LOW_AVERAGES (1),
      .TEMP_W       (16)
   ) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .shot_wr     (shot_wr),
      .free_run    (free_run),
      .slow_start  (slow_start),
      .slow_enable (slow_enable),
      .avg_sel     (avg_sel),
      .soft_rst    (soft_rst),
      .bdu_en      (bdu_en),
      .rd_lo       (rd_lo),
      .rd_hi       (rd_hi),
      .conv_done   (conv_done),
      .conv_result (conv_result),
      .conv_start  (conv_start),
      .conv_avg    (conv_avg),
      .busy        (busy),
      .temp_lo     (temp_lo),
      .temp_hi     (temp_hi),
      .new_sample  (new_sample)
   );

   assign conv_result = sample_val;

   // converter model: answers lat_cfg cycles after the start (0 = next cycle)
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_done  <= 1'b0;
         cd         <= 0;
         sample_val <= FIRST_VAL;
      end else begin
         conv_done <= 1'b0;
         if (conv_done) sample_val <= sample_val + STEP_VAL;
         if (conv_start) begin
            if (lat_cfg == 0) conv_done <= 1'b1;
            else              cd <= lat_cfg;
         end else if (cd != 0) begin
            cd <= cd - 1;
            if (cd == 1) conv_done <= 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      if (conv_start) n_starts <= n_starts + 1;
      if (new_sample) n_new <= n_new + 1;
      if (conv_done)  n_done <= n_done + 1;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic wait_start(input int limit, output int seen_at);
      seen_at = -1;
      for (int k = 0; k < limit; k++) begin
         @(negedge clk);
         if (conv_start) begin
            seen_at = k;
            break;
         end
      end
   endtask

   task automatic setup(input int fr, input int ls, input int en, input int av);
      @(negedge clk);
      free_run    = 1'b0;
      slow_start  = 1'b0;
      slow_enable = en[0];
      soft_rst    = 1'b1;
      cycles(2);
      soft_rst = 1'b0;
      @(negedge clk);
      free_run   = fr[0];
      slow_start = ls[0];
      avg_sel    = av[1:0];
   endtask

   function automatic string vec_tag(input int i);
      if (i == 4 || i == 6) return "R5";
      if (i == 5) return "R9";
      return "R1";
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int base, gap, seen, av;
      logic [7:0] keep_hi, keep_lo;
      logic [15:0] exp_word;

      cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R6: reset values
      chk("R6 busy", int'(busy), 0);
      chk("R6 start", int'(conv_start), 0);
      chk("R6 word", int'({temp_hi, temp_lo}), 0);
      chk("R6 strobe", int'(new_sample), 0);

      // R3 R4 R2: one-shot with a slow converter
      lat_cfg = 8;
      setup(0, 0, 0, 1);
      base = n_starts;
      @(negedge clk); shot_wr = 1'b1;
      @(negedge clk); shot_wr = 1'b0;
      chk("R4 busy at start", int'(busy), 1);
      chk("R2 one-shot average", int'(conv_avg), 4);
      cycles(4);
      chk("R4 busy mid", int'(busy), 1);
      cycles(20);
      chk("R10 busy cleared", int'(busy), 0);
      chk("R3 one start", n_starts - base, 1);
      chk("R8 signed word", int'({temp_hi, temp_lo}), int'(FIRST_VAL));
      chk("R8 strobe count", n_new, n_done);

      // R10: second write runs again, result wraps to positive
      @(negedge clk); shot_wr = 1'b1;
      @(negedge clk); shot_wr = 1'b0;
      cycles(24);
      chk("R10 second start", n_starts - base, 2);
      chk("R8 high byte", int'(temp_hi), 8'h00);
      chk("R8 low byte", int'(temp_lo), 8'h5B);

      // rate vectors (R1 R2 R5 R9)
      lat_cfg = 0;
      for (int i = 0; i < NV; i++) begin
         setup(V_FR[i], V_LS[i], V_EN[i], V_AVG[i]);
         if (V_GAP[i] == 0) begin
            base = n_starts;
            cycles(600);
            chk(vec_tag(i), n_starts - base, 0);
         end else begin
            wait_start(1000, seen);
            av = int'(conv_avg);
            gap = 0;
            for (int k = 0; k < 1000; k++) begin
               @(negedge clk);
               gap++;
               if (conv_start) break;
            end
            chk(vec_tag(i), gap, V_GAP[i]);
            chk((i == 4) ? "R5 average" : "R2 average", av, V_NAV[i]);
         end
      end

      // R4: one-shot write ignored in free-run
      setup(1, 0, 0, 0);
      @(negedge clk); shot_wr = 1'b1;
      @(negedge clk); shot_wr = 1'b0;
      chk("R4 ignored write", int'(busy), 0);

      // R7: block-update lock
      bdu_en = 1'b1;
      cycles(40);
      @(negedge clk);
      rd_lo = 1'b1;
      keep_hi = temp_hi;
      keep_lo = temp_lo;
      @(negedge clk); rd_lo = 1'b0;
      cycles(50);
      chk("R7 high held", int'(temp_hi), int'(keep_hi));
      chk("R7 low held", int'(temp_lo), int'(keep_lo));
      @(negedge clk); rd_hi = 1'b1;
      @(negedge clk); rd_hi = 1'b0;
      exp_word = sample_val - STEP_VAL;
      chk("R7 newest after release", int'({temp_hi, temp_lo}), int'(exp_word));
      bdu_en = 1'b0;
      @(negedge clk); rd_lo = 1'b1;
      @(negedge clk); rd_lo = 1'b0;
      cycles(50);
      exp_word = sample_val - STEP_VAL;
      chk("R7 unlocked follows", int'({temp_hi, temp_lo}), int'(exp_word));

      // R6: soft reset during free-run
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk);
      chk("R6 soft word", int'({temp_hi, temp_lo}), 0);
      base = n_starts;
      cycles(40);
      chk("R6 soft quiet", n_starts - base, 0);
      soft_rst = 1'b0;
      wait_start(100, seen);
      chk("R6 resumes", int'(seen >= 0), 1);

      // R11: direct switch stops, passing through zero restarts
      @(negedge clk);
      free_run = 1'b0; slow_start = 1'b1; slow_enable = 1'b1;
      @(negedge clk);
      base = n_starts;
      cycles(600);
      chk("R11 switch halts", n_starts - base, 0);
      slow_start = 1'b0;
      cycles(2);
      slow_start = 1'b1;
      wait_start(1000, seen);
      chk("R11 slow after clear", seen, 400);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule